// File: doc/BRIEF.md
# Serial Row-Select Sequencer for Shift-Register Row Drivers

Some LED matrix panels select the active row with a serial shift register instead of a binary decoder. This block turns the three lowest row-address lines into a bit-banged serial port: line 0 is the shift clock, line 1 is the serial data and line 2 is the blank/update strobe. For each row update it shifts an 8-bit one-hot row pattern into the driver. The upper address lines keep carrying the binary row address.

A controller pulses `start` with the row index when the last 16 pixel slots of that row's stream begin. It then raises `slot_en` once per pixel slot. Each enabled cycle moves the sequence forward by one slot, so the address word can be merged slot by slot into the pixel stream. Between sequences the low three lines are held at zero. During the least-significant colour plane the controller raises `lsb_plane`, and the upper lines then show the previous row, so that the row displayed during that plane stays consistent.

Top module: `rowsel_seq`

## Requirements
- R1: After reset `busy` and `done` are 0 and `addr_word` shows the idle form of the current inputs.
- R2: When idle, field bits 0..2 are 0 and field bits 3..4 equal the upper bits of the displayed row. The field starts at bit `ADDR_OFS` of `addr_word`, and every word bit outside the field is 0.
- R3: A `start` pulse while idle latches `row_idx`. From the next cycle `busy` is 1 and slot 0 is shown.
- R4: Each cycle with `slot_en` high while busy advances one slot. With `slot_en` low the three serial lines hold their values.
- R5: The sequence lasts 16 slots (0..15). Field bit 0, the clock, is 1 in even slots and 0 in odd slots.
- R6: Slots 2j and 2j+1 carry serial bit k = 7 - j on field bit 1. That bit is 1 only when (latched row mod 8) equals k, so the 8 values seen while the clock is low form a one-hot pattern.
- R7: Field bit 2, blank/update, is 1 in every slot of the sequence.
- R8: While busy, field bits 3..4 come from the latched row, not from the live `row_idx`.
- R9: With `lsb_plane` high the displayed row is (row - 1) mod 32, for example 0 becomes 31. This affects field bits 3..4 only and never the serial one-hot data.
- R10: When slot 15 is advanced out, `done` is 1 for exactly the next cycle and `busy` falls, unless R11 applies.
- R11: A `start` pulse while busy is ignored, except in the cycle in which slot 15 retires. There it begins a new sequence immediately: the next cycle shows slot 0 of the new row with `busy` 1 and `done` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence for `row_idx` |
| slot_en | input | 1 | Advance one pixel slot |
| row_idx | input | ROW_W | Row index |
| lsb_plane | input | 1 | Least-significant plane: show the previous row on the upper lines |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the final slot |
| addr_word | output | WORD_W | Per-slot word carrying the address field at `ADDR_OFS` |

## Verification
Retirement of the final slot and acceptance of a new start can fall in the same cycle. The bench provokes this by raising `start` with a different row on the cycle that advances slot 15. It then expects `done` and `busy` both high, together with slot 0 of the new row, and it checks the whole following sequence. A start raised in the middle of a sequence, and cycles with `slot_en` low, are interleaved with the sweep over all 32 rows and both plane settings. For each row, the clock-low data samples are assembled and compared with the one-hot pattern.

// File: rtl/rowsel_pkg.sv
package rowsel_pkg;
  localparam int LN_CLK  = 0;
  localparam int LN_DAT  = 1;
  localparam int LN_BLK  = 2;
  localparam int LN_CTRL = 3;

  typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} seq_st_t;
endpackage

// File: rtl/rowsel_rst_sync.sv
module rowsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/rowsel_slot_ctr.sv
module rowsel_slot_ctr
  import rowsel_pkg::*;
#(
  parameter int ROW_W = 5,
  parameter int SLOTS = 16,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              busy_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              done_o
);
  seq_st_t           st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [ROW_W-1:0]  row_q;
  logic              done_q, done_d;
  logic              slot_ce, row_ce, last_w;

  assign last_w = (st_q == ST_SHIFT) && adv_i && (slot_q == SLOT_W'(SLOTS - 1));

  // next-state
  always_comb begin
    st_d    = st_q;
    slot_d  = slot_q;
    slot_ce = 1'b0;
    row_ce  = 1'b0;
    done_d  = last_w;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_SHIFT;
          slot_d  = '0;
          slot_ce = 1'b1;
          row_ce  = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (adv_i) begin
          slot_ce = 1'b1;
          if (last_w) begin
            slot_d = '0;
            if (start_i) row_ce = 1'b1;
            else         st_d   = ST_IDLE;
          end else begin
            slot_d = SLOT_W'(slot_q + 1'b1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      row_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (slot_ce) slot_q <= slot_d;
      if (row_ce)  row_q  <= row_i;
    end
  end

  assign busy_o = (st_q == ST_SHIFT);
  assign slot_o = slot_q;
  assign row_o  = row_q;
  assign done_o = done_q;
endmodule

// File: rtl/rowsel_bit_enc.sv
module rowsel_bit_enc
  import rowsel_pkg::*;
#(
  parameter int SER_BITS = 8,
  localparam int SEL_W  = $clog2(SER_BITS),
  localparam int SLOT_W = SEL_W + 1
) (
  input  logic              busy_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [LN_CTRL-1:0] ctrl_o
);
  logic [SER_BITS-1:0] hot_w;
  logic [SEL_W-1:0]    bit_k;

  for (genvar k = 0; k < SER_BITS; k++) begin : g_hot
    assign hot_w[k] = (sel_i == SEL_W'(k));
  end

  assign bit_k = SEL_W'(SER_BITS - 1) - slot_i[SLOT_W-1:1];

  always_comb begin
    ctrl_o = '0;
    if (busy_i) begin
      ctrl_o[LN_CLK] = ~slot_i[0];
      ctrl_o[LN_DAT] = hot_w[bit_k];
      ctrl_o[LN_BLK] = 1'b1;
    end
  end
endmodule

// File: rtl/rowsel_field_mux.sv
module rowsel_field_mux
  import rowsel_pkg::*;
#(
  parameter int ROW_W    = 5,
  parameter int WORD_W   = 16,
  parameter int ADDR_OFS = 0
) (
  input  logic               busy_i,
  input  logic [LN_CTRL-1:0] ctrl_i,
  input  logic [ROW_W-1:0]   row_live_i,
  input  logic [ROW_W-1:0]   row_lat_i,
  input  logic               prev_i,
  output logic [WORD_W-1:0]  word_o
);
  logic [ROW_W-1:0] base_w, disp_w, field_w;

  always_comb begin
    base_w  = busy_i ? row_lat_i : row_live_i;
    disp_w  = prev_i ? ROW_W'(base_w - 1'b1) : base_w;
    field_w = {disp_w[ROW_W-1:LN_CTRL], ctrl_i};
  end

  for (genvar i = 0; i < WORD_W; i++) begin : g_word
    if (i >= ADDR_OFS && i < ADDR_OFS + ROW_W) begin : g_fld
      assign word_o[i] = field_w[i-ADDR_OFS];
    end else begin : g_zero
      assign word_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rowsel_seq.sv
module rowsel_seq
  import rowsel_pkg::*;
#(
  parameter int ROW_W    = 5,
  parameter int SER_BITS = 8,
  parameter int WORD_W   = 16,
  parameter int ADDR_OFS = 0,
  localparam int SLOTS  = 2 * SER_BITS,
  localparam int SEL_W  = $clog2(SER_BITS),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              slot_en,
  input  logic [ROW_W-1:0]  row_idx,
  input  logic              lsb_plane,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] addr_word
);
  logic               rst_s;
  logic               busy_w;
  logic [SLOT_W-1:0]  slot_w;
  logic [ROW_W-1:0]   row_lat;
  logic [LN_CTRL-1:0] ctrl_w;

  rowsel_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_s)
  );

  rowsel_slot_ctr #(.ROW_W(ROW_W), .SLOTS(SLOTS)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_s),
    .start_i (start),
    .adv_i   (slot_en),
    .row_i   (row_idx),
    .busy_o  (busy_w),
    .slot_o  (slot_w),
    .row_o   (row_lat),
    .done_o  (done)
  );

  rowsel_bit_enc #(.SER_BITS(SER_BITS)) u_enc (
    .busy_i (busy_w),
    .slot_i (slot_w),
    .sel_i  (row_lat[SEL_W-1:0]),
    .ctrl_o (ctrl_w)
  );

  rowsel_field_mux #(.ROW_W(ROW_W), .WORD_W(WORD_W), .ADDR_OFS(ADDR_OFS)) u_mux (
    .busy_i     (busy_w),
    .ctrl_i     (ctrl_w),
    .row_live_i (row_idx),
    .row_lat_i  (row_lat),
    .prev_i     (lsb_plane),
    .word_o     (addr_word)
  );

  assign busy = busy_w;
endmodule

// File: rtl/rowsel_chk.sv
module rowsel_chk #(
  parameter int WORD_W   = 16,
  parameter int ADDR_OFS = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              slot_en,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] addr_word
);
  logic ln_clk, ln_dat, ln_blk;
  assign ln_clk = addr_word[ADDR_OFS];
  assign ln_dat = addr_word[ADDR_OFS+1];
  assign ln_blk = addr_word[ADDR_OFS+2];

  AST_IDLE_CTRL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ln_clk && !ln_dat && !ln_blk)); // R2
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy); // R3
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slot_en) |=> (busy && $stable(ln_clk) && $stable(ln_dat) && $stable(ln_blk))); // R4
  AST_CLK_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot_en && ln_clk) |=> (busy && !ln_clk)); // R5
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot_en && ln_clk) |=> $stable(ln_dat)); // R6
  AST_BLANK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ln_blk); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy) |-> $past(start)); // R11
endmodule

bind rowsel_seq rowsel_chk #(.WORD_W(WORD_W), .ADDR_OFS(ADDR_OFS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .start     (start),
  .slot_en   (slot_en),
  .busy      (busy),
  .done      (done),
  .addr_word (addr_word)
);

// File: tb/sim_rowsel_seq.sv
`timescale 1ns/1ps
module sim_rowsel_seq;
  localparam int ROW_W = 5;
  localparam int WORD_W = 16;
  localparam int OFS = 0;
  localparam real TCK = 5.0;

  logic clk = 1'b0;
  logic rst_n, start, slot_en, lsb_plane;
  logic [ROW_W-1:0] row_idx;
  logic busy, done;
  logic [WORD_W-1:0] addr_word;

  int n_cmp = 0;
  int n_bad = 0;

  always #(TCK/2) clk = ~clk;

  rowsel_seq #(.ROW_W(ROW_W), .SER_BITS(8), .WORD_W(WORD_W), .ADDR_OFS(OFS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_en(slot_en),
    .row_idx(row_idx), .lsb_plane(lsb_plane),
    .busy(busy), .done(done), .addr_word(addr_word)
  );

  function automatic logic [WORD_W-1:0] exp_word(input logic act, input int slot,
                                                 input int rv, input logic prv);
    int disp, fld, k;
    disp = prv ? ((rv + 31) % 32) : rv;
    fld = (disp / 8) * 8;
    if (act) begin
      k = 7 - slot / 2;
      fld += 4;
      if ((rv % 8) == k) fld += 2;
      if ((slot % 2) == 0) fld += 1;
    end
    return WORD_W'(fld) << OFS;
  endfunction

  task automatic cmp(input string req, input logic [WORD_W-1:0] act,
                     input logic [WORD_W-1:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one sequence; gaps inserts idle slot_en cycles, poke_busy raises start mid-way,
  // nxt >= 0 restarts on the retiring cycle with that row
  task automatic run_seq(input int rv, input logic prv, input logic gaps,
                         input logic poke_busy, input int nxt);
    logic [7:0] hot;
    hot = '0;
    row_idx = ROW_W'(rv); lsb_plane = prv; slot_en = 1'b0; start = 1'b0;
    #1;
    cmp("R2 idle word", addr_word, exp_word(1'b0, 0, rv, prv));
    start = 1'b1;
    tick();
    start = 1'b0;
    cmp("R3 busy after start", WORD_W'(busy), WORD_W'(1));
    cmp("R3 slot0", addr_word, exp_word(1'b1, 0, rv, prv));
    for (int s = 0; s < 16; s++) begin
      if (s % 2 == 1) hot[7 - s/2] = addr_word[OFS+1];
      if (gaps && (s % 3 == 1)) begin
        slot_en = 1'b0;
        row_idx = ROW_W'(rv ^ 31);
        tick();
        cmp("R4 hold R8 latched row", addr_word, exp_word(1'b1, s, rv, prv));
        row_idx = ROW_W'(rv);
      end
      slot_en = 1'b1;
      if (poke_busy && s == 5) begin
        start = 1'b1; row_idx = ROW_W'(rv ^ 21);
      end
      if (s == 15 && nxt >= 0) begin
        start = 1'b1; row_idx = ROW_W'(nxt);
      end
      tick();
      start = 1'b0;
      if (s < 15) begin
        row_idx = ROW_W'(rv);
        cmp("R5 R7 slot word", addr_word, exp_word(1'b1, s + 1, rv, prv));
      end
    end
    slot_en = 1'b0;
    cmp("R6 one-hot", WORD_W'(hot), WORD_W'(1) << (rv % 8));
    cmp("R10 done pulse", WORD_W'(done), WORD_W'(1));
    if (nxt >= 0) begin
      cmp("R11 restart busy", WORD_W'(busy), WORD_W'(1));
      cmp("R11 restart slot0", addr_word, exp_word(1'b1, 0, nxt, prv));
    end else begin
      cmp("R10 busy low", WORD_W'(busy), WORD_W'(0));
      cmp("R2 idle after", addr_word, exp_word(1'b0, 0, rv, prv));
      tick();
      cmp("R10 done single", WORD_W'(done), WORD_W'(0));
    end
  endtask

  initial begin
    #(TCK * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; slot_en = 1'b0; lsb_plane = 1'b0; row_idx = '0;
    repeat (3) tick();
    cmp("R1 reset busy", WORD_W'(busy), WORD_W'(0));
    cmp("R1 reset done", WORD_W'(done), WORD_W'(0));
    cmp("R1 reset word", addr_word, exp_word(1'b0, 0, 0, 1'b0));
    rst_n = 1'b1;
    repeat (4) tick();
    cmp("R1 post reset idle", WORD_W'(busy), WORD_W'(0));
    // R9 wrap: row 0 with previous-row selection shows row 31 upper bits
    row_idx = '0; lsb_plane = 1'b1; #1;
    cmp("R9 wrap idle", addr_word, WORD_W'(24) << OFS);
    for (int r = 0; r < 32; r++) begin
      for (int p = 0; p < 2; p++) begin
        run_seq(r, logic'(p), logic'((r + p) % 2), logic'(r % 4 == 2), -1);
      end
    end
    // R11 back-to-back: restart on the retiring slot, then finish the new row
    run_seq(13, 1'b0, 1'b0, 1'b0, 26);
    slot_en = 1'b1; row_idx = 5'd26;
    for (int s = 1; s < 16; s++) begin
      tick();
      cmp("R11 second seq", addr_word, exp_word(1'b1, s, 26, 1'b0));
    end
    tick();
    slot_en = 1'b0;
    cmp("R11 second done", WORD_W'(done), WORD_W'(1));
    cmp("R11 idle after", WORD_W'(busy), WORD_W'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule